// File: doc/BRIEF.md
# Instruction Decoder with Upper-Immediate Prefix

This block decodes one 32-bit instruction word per cycle for a small RISC core with 32 registers. The word arrives in memory byte order and is byte-reversed before any field is taken. The decoder outputs the opcode and the destination and source register numbers. It classifies the word as register-register, register-immediate or reserved, and it forms the 32-bit immediate operand that the execute stage consumes. The decode path is combinational. The only registered state is the prefix latch.

A register-immediate word normally carries a 16-bit immediate that is sign-extended to 32 bits. A dedicated prefix opcode loads its own 16-bit field into a latch as the upper half of the next operand and arms a pending flag. The next valid word, whatever its kind, uses up that flag. If that word is register-immediate, its operand is the latched upper half joined to its own 16 bits, and no sign extension takes place. Exception entry and reset drop a pending prefix. A word fetched with a bus error produces no decode output and is reported on a separate error flag.

Top module: `insn_decode`

## Requirements
- R1: The word on `in_word` is taken in memory byte order and its four bytes are reversed before decode. After the reversal, the opcode is bits 31:26, the destination register is bits 25:21 and source register A is bits 20:16, in every format.
- R2: An opcode with bit 3 clear that is not reserved decodes as register-register (`out_fmt` = 0). Source B comes from bits 15:11 and the 11-bit field from bits 10:0, and `out_operand` is zero.
- R3: An opcode with bit 3 set that is not reserved decodes as register-immediate (`out_fmt` = 1), with `out_rb` and `out_imm11` at zero.
- R4: An opcode marked in the reserved map decodes as reserved (`out_fmt` = 2) and raises `out_rsvd`. By default the map marks opcodes 62 and 63. `out_rb`, `out_imm11` and `out_operand` are zero, while `out_rd` and `out_ra` still carry their fields.
- R5: With no prefix pending, a register-immediate operand is bits 15:0 sign-extended, so bit 15 set gives an upper half of all ones.
- R6: With a prefix pending, a register-immediate operand is the latched prefix field in bits 31:16 ORed with the current 16-bit field, with no sign extension.
- R7: A valid, error-free word with the prefix opcode (default 44, hex 2C) latches its bits 15:0 and arms the pending flag. Its own operand follows R5 or R6. The next valid word of any kind uses up the flag. Cycles with `in_valid` low leave it unchanged.
- R8: `exc_enter` clears the pending flag at the next clock edge, even when a prefix word arrives in the same cycle. The decode outputs of that same cycle are unaffected.
- R9: A valid word with `in_fetch_err` set drives `out_ibe` high, holds `out_valid` low and zeroes every decode output. It uses up a pending prefix and never arms one.
- R10: Asynchronous active-low reset clears the pending flag. With `in_valid` low, `out_valid`, `out_ibe` and every decode output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A fetched word is present this cycle |
| in_word | input | 32 | Fetched word, memory byte order |
| in_fetch_err | input | 1 | The fetch of this word failed |
| exc_enter | input | 1 | Exception entry, drops a pending prefix |
| out_valid | output | 1 | Decode outputs are meaningful |
| out_opcode | output | 6 | Primary opcode |
| out_rd | output | 5 | Destination register |
| out_ra | output | 5 | Source register A |
| out_rb | output | 5 | Source register B (register-register only) |
| out_imm11 | output | 11 | Low 11-bit field (register-register only) |
| out_fmt | output | 2 | 0 register-register, 1 register-immediate, 2 reserved |
| out_operand | output | 32 | Final immediate operand |
| out_rsvd | output | 1 | Reserved opcode seen |
| out_ibe | output | 1 | Instruction bus error passed on |

## Verification
Several rules are checked on every cycle against the pending flag: that a prefix arms the flag, that any other valid word or exception entry drops it, and that idle cycles hold it. The same checks cover sign extension while nothing is pending, the exclusivity of the bus-error flag and the zeroed operand of reserved words. The exact value of a prefixed operand depends on a word that may have arrived many cycles earlier, so only the bench's sequences show it. The same holds for the byte reversal, the field positions, and the chains of prefix, idle, error, exception and reserved words that test when the prefix is consumed.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

   typedef enum logic [1:0] {
      FMT_RR  = 2'd0,
      FMT_RI  = 2'd1,
      FMT_RSV = 2'd2
   } fmt_e;

endpackage

// File: rtl/insn_byte_order.sv
module insn_byte_order #(
   parameter int unsigned IW   = 32,
   parameter bit          SWAP = 1'b1
) (
   input  logic [IW-1:0] word_mem,
   output logic [IW-1:0] word_log
);
   localparam int unsigned NBYTES = IW / 8;

   if (IW % 8 != 0) begin : g_bad_iw
      $error("insn_byte_order: IW must be a whole number of bytes");
   end

   if (SWAP) begin : g_swap
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         assign word_log[8*b +: 8] = word_mem[IW-8-8*b +: 8];
      end
   end else begin : g_pass
      assign word_log = word_mem;
   end
endmodule

// File: rtl/insn_field_split.sv
module insn_field_split
   import insn_dec_pkg::*;
#(
   parameter int unsigned        IW       = 32,
   parameter int unsigned        OPW      = 6,
   parameter int unsigned        RW       = 5,
   parameter int unsigned        IMMW     = 16,
   parameter int unsigned        LOWW     = 11,
   parameter int unsigned        RI_BIT   = 3,
   parameter logic [(1<<OPW)-1:0] RSVD_MAP = '0
) (
   input  logic [IW-1:0]   word,
   output logic [OPW-1:0]  opcode,
   output logic [RW-1:0]   rd,
   output logic [RW-1:0]   ra,
   output logic [RW-1:0]   rb,
   output logic [LOWW-1:0] low11,
   output logic [IMMW-1:0] imm16,
   output fmt_e            fmt
);
   localparam int unsigned NOPS   = 1 << OPW;
   localparam int unsigned RD_LSB = IW - OPW - RW;
   localparam int unsigned RA_LSB = RD_LSB - RW;
   localparam int unsigned RB_LSB = LOWW;

   if (OPW + 2*RW + IMMW != IW) begin : g_bad_split
      $error("insn_field_split: opcode, registers and immediate must fill the word");
   end
   if (RW + LOWW != IMMW) begin : g_bad_low
      $error("insn_field_split: source B and low field must fill the immediate slot");
   end
   if (RI_BIT >= OPW) begin : g_bad_ribit
      $error("insn_field_split: format select bit outside the opcode");
   end

   fmt_e cls_tab [NOPS];

   for (genvar g = 0; g < NOPS; g++) begin : g_cls
      localparam logic [OPW-1:0] OPV = OPW'(g);
      if (RSVD_MAP[g]) begin : g_rsv
         assign cls_tab[g] = FMT_RSV;
      end else if (OPV[RI_BIT]) begin : g_ri
         assign cls_tab[g] = FMT_RI;
      end else begin : g_rr
         assign cls_tab[g] = FMT_RR;
      end
   end

   assign opcode = word[IW-1 -: OPW];
   assign rd     = word[RD_LSB +: RW];
   assign ra     = word[RA_LSB +: RW];
   assign rb     = word[RB_LSB +: RW];
   assign low11  = word[0 +: LOWW];
   assign imm16  = word[0 +: IMMW];
   assign fmt    = cls_tab[opcode];
endmodule

// File: rtl/imm_prefix_unit.sv
module imm_prefix_unit #(
   parameter int unsigned   IMMW   = 16,
   parameter int unsigned   OPW    = 6,
   parameter logic [OPW-1:0] PFX_OP = OPW'(44)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              accept,
   input  logic              exc_enter,
   input  logic              is_ri,
   input  logic [OPW-1:0]    opcode,
   input  logic [IMMW-1:0]   imm16,
   output logic [2*IMMW-1:0] operand,
   output logic              pend
);
   localparam int unsigned OW = 2 * IMMW;

   logic [IMMW-1:0] hi_q;
   logic            is_pfx;
   logic [OW-1:0]   ext_val;

   assign is_pfx  = accept && (opcode == PFX_OP);
   assign ext_val = pend ? ({hi_q, {IMMW{1'b0}}} | {{IMMW{1'b0}}, imm16})
                         : {{IMMW{imm16[IMMW-1]}}, imm16};
   assign operand = (accept && is_ri) ? ext_val : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         hi_q <= '0;
      end else begin
         if (exc_enter) begin
            pend <= 1'b0;
         end else if (take) begin
            pend <= is_pfx;
         end
         if (is_pfx && !exc_enter) begin
            hi_q <= imm16;
         end
      end
   end
endmodule

// File: rtl/insn_decode.sv
module insn_decode
   import insn_dec_pkg::*;
#(
   parameter int unsigned         IW       = 32,
   parameter int unsigned         OPW      = 6,
   parameter int unsigned         RW       = 5,
   parameter int unsigned         IMMW     = 16,
   parameter int unsigned         LOWW     = 11,
   parameter int unsigned         RI_BIT   = 3,
   parameter bit                  SWAP     = 1'b1,
   parameter logic [OPW-1:0]      PFX_OP   = OPW'(44),
   parameter logic [(1<<OPW)-1:0] RSVD_MAP = {2'b11, {((1<<OPW)-2){1'b0}}}
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [IW-1:0]   in_word,
   input  logic            in_fetch_err,
   input  logic            exc_enter,
   output logic            out_valid,
   output logic [OPW-1:0]  out_opcode,
   output logic [RW-1:0]   out_rd,
   output logic [RW-1:0]   out_ra,
   output logic [RW-1:0]   out_rb,
   output logic [LOWW-1:0] out_imm11,
   output logic [1:0]      out_fmt,
   output logic [IW-1:0]   out_operand,
   output logic            out_rsvd,
   output logic            out_ibe
);
   if (2*IMMW != IW) begin : g_bad_imm
      $error("insn_decode: prefix plus immediate must equal the word width");
   end
   if (RSVD_MAP[PFX_OP]) begin : g_bad_pfx_rsv
      $error("insn_decode: prefix opcode may not be reserved");
   end
   if (!PFX_OP[RI_BIT]) begin : g_bad_pfx_fmt
      $error("insn_decode: prefix opcode must be register-immediate");
   end

   logic [IW-1:0]   word_l;
   logic [OPW-1:0]  f_op;
   logic [RW-1:0]   f_rd, f_ra, f_rb;
   logic [LOWW-1:0] f_low;
   logic [IMMW-1:0] f_imm;
   fmt_e            f_fmt;
   logic            acc;
   logic            pfx_pend;
   logic [IW-1:0]   opnd;

   insn_byte_order #(.IW(IW), .SWAP(SWAP)) u_order (
      .word_mem (in_word),
      .word_log (word_l)
   );

   insn_field_split #(
      .IW(IW), .OPW(OPW), .RW(RW), .IMMW(IMMW), .LOWW(LOWW),
      .RI_BIT(RI_BIT), .RSVD_MAP(RSVD_MAP)
   ) u_split (
      .word   (word_l),
      .opcode (f_op),
      .rd     (f_rd),
      .ra     (f_ra),
      .rb     (f_rb),
      .low11  (f_low),
      .imm16  (f_imm),
      .fmt    (f_fmt)
   );

   assign acc = in_valid && !in_fetch_err;

   imm_prefix_unit #(.IMMW(IMMW), .OPW(OPW), .PFX_OP(PFX_OP)) u_pfx (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (in_valid),
      .accept    (acc),
      .exc_enter (exc_enter),
      .is_ri     (f_fmt == FMT_RI),
      .opcode    (f_op),
      .imm16     (f_imm),
      .operand   (opnd),
      .pend      (pfx_pend)
   );

   always_comb begin
      out_valid   = acc;
      out_ibe     = in_valid && in_fetch_err;
      out_opcode  = '0;
      out_rd      = '0;
      out_ra      = '0;
      out_rb      = '0;
      out_imm11   = '0;
      out_fmt     = FMT_RR;
      out_rsvd    = 1'b0;
      out_operand = opnd;
      if (acc) begin
         out_opcode = f_op;
         out_rd     = f_rd;
         out_ra     = f_ra;
         out_fmt    = f_fmt;
         out_rsvd   = (f_fmt == FMT_RSV);
         if (f_fmt == FMT_RR) begin
            out_rb    = f_rb;
            out_imm11 = f_low;
         end
      end
   end
endmodule

// File: rtl/insn_decode_chk.sv
module insn_decode_chk #(
   parameter int unsigned    IW     = 32,
   parameter int unsigned    OPW    = 6,
   parameter logic [OPW-1:0] PFX_OP = OPW'(44)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic           in_fetch_err,
   input logic           exc_enter,
   input logic           out_valid,
   input logic [OPW-1:0] out_opcode,
   input logic [1:0]     out_fmt,
   input logic [IW-1:0]  out_operand,
   input logic           out_rsvd,
   input logic           out_ibe,
   input logic           pfx_pend
);
   localparam int unsigned HW = IW / 2;

   // R9
   ibe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fetch_err) |-> (out_ibe && !out_valid && out_operand == '0 && out_fmt == 2'd0));

   // R4
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_rsvd |-> (out_fmt == 2'd2 && out_operand == '0));

   // R5
   sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fmt == 2'd1 && !pfx_pend) |-> (out_operand[IW-1:HW] == {HW{out_operand[HW-1]}}));

   // R7
   pfx_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_opcode == PFX_OP && !exc_enter) |=> pfx_pend);

   // R7
   pfx_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !(out_valid && out_opcode == PFX_OP)) |=> !pfx_pend);

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !exc_enter) |=> $stable(pfx_pend));

   // R8
   exc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_enter |=> !pfx_pend);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!out_valid && !out_ibe && !out_rsvd));
endmodule

bind insn_decode insn_decode_chk #(.IW(IW), .OPW(OPW), .PFX_OP(PFX_OP)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_fetch_err (in_fetch_err),
   .exc_enter    (exc_enter),
   .out_valid    (out_valid),
   .out_opcode   (out_opcode),
   .out_fmt      (out_fmt),
   .out_operand  (out_operand),
   .out_rsvd     (out_rsvd),
   .out_ibe      (out_ibe),
   .pfx_pend     (pfx_pend)
);

// File: tb/test_insn_decode.sv
module test_insn_decode;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        in_fetch_err = 1'b0;
   logic        exc_enter = 1'b0;
   logic        out_valid;
   logic [5:0]  out_opcode;
   logic [4:0]  out_rd, out_ra, out_rb;
   logic [10:0] out_imm11;
   logic [1:0]  out_fmt;
   logic [31:0] out_operand;
   logic        out_rsvd, out_ibe;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   insn_decode i_insn_decode (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .in_fetch_err(in_fetch_err), .exc_enter(exc_enter),
      .out_valid(out_valid), .out_opcode(out_opcode), .out_rd(out_rd),
      .out_ra(out_ra), .out_rb(out_rb), .out_imm11(out_imm11),
      .out_fmt(out_fmt), .out_operand(out_operand), .out_rsvd(out_rsvd),
      .out_ibe(out_ibe)
   );

   // entry: {req[3:0], valid, ferr, exc, word[31:0], fmt[1:0], operand[31:0], ibe}
   localparam int NV = 31;
   localparam logic [73:0] VEC [NV] = '{
      {4'd3,  3'b100, 32'h2064_1234, 2'd1, 32'h0000_1234, 1'b0}, // R3 R5
      {4'd5,  3'b100, 32'h2022_8001, 2'd1, 32'hFFFF_8001, 1'b0}, // R5 negative
      {4'd2,  3'b100, 32'h00A6_3923, 2'd0, 32'h0000_0000, 1'b0}, // R2
      {4'd7,  3'b100, 32'hB000_ABCD, 2'd1, 32'hFFFF_ABCD, 1'b0}, // R7 prefix
      {4'd6,  3'b100, 32'h2022_8001, 2'd1, 32'hABCD_8001, 1'b0}, // R6
      {4'd7,  3'b100, 32'h2022_8001, 2'd1, 32'hFFFF_8001, 1'b0}, // R7 used up
      {4'd7,  3'b100, 32'hB000_1111, 2'd1, 32'h0000_1111, 1'b0}, // R7
      {4'd10, 3'b000, 32'h2022_8001, 2'd0, 32'h0000_0000, 1'b0}, // R10 idle
      {4'd7,  3'b100, 32'h3000_0002, 2'd1, 32'h1111_0002, 1'b0}, // R7 idle kept
      {4'd7,  3'b100, 32'hB000_00FF, 2'd1, 32'h0000_00FF, 1'b0}, // R7
      {4'd7,  3'b100, 32'h00A6_3923, 2'd0, 32'h0000_0000, 1'b0}, // R7 by RR
      {4'd7,  3'b100, 32'h3000_0002, 2'd1, 32'h0000_0002, 1'b0}, // R7
      {4'd4,  3'b100, 32'hFC43_0005, 2'd2, 32'h0000_0000, 1'b0}, // R4
      {4'd7,  3'b100, 32'hB000_2222, 2'd1, 32'h0000_2222, 1'b0}, // R7
      {4'd9,  3'b110, 32'h3000_0002, 2'd0, 32'h0000_0000, 1'b1}, // R9 error
      {4'd9,  3'b100, 32'h3000_0002, 2'd1, 32'h0000_0002, 1'b0}, // R9 used up
      {4'd9,  3'b110, 32'hB000_3333, 2'd0, 32'h0000_0000, 1'b1}, // R9 errored prefix
      {4'd9,  3'b100, 32'h3000_0002, 2'd1, 32'h0000_0002, 1'b0}, // R9 not armed
      {4'd7,  3'b100, 32'hB000_4444, 2'd1, 32'h0000_4444, 1'b0}, // R7
      {4'd8,  3'b101, 32'h3000_0002, 2'd1, 32'h4444_0002, 1'b0}, // R8 same cycle
      {4'd8,  3'b101, 32'hB000_5555, 2'd1, 32'h0000_5555, 1'b0}, // R8 beats prefix
      {4'd8,  3'b100, 32'h3000_0002, 2'd1, 32'h0000_0002, 1'b0}, // R8
      {4'd7,  3'b100, 32'hB000_6666, 2'd1, 32'h0000_6666, 1'b0}, // R7
      {4'd8,  3'b001, 32'h3000_0002, 2'd0, 32'h0000_0000, 1'b0}, // R8 idle exc
      {4'd8,  3'b100, 32'h3000_0002, 2'd1, 32'h0000_0002, 1'b0}, // R8
      {4'd7,  3'b100, 32'hB000_7777, 2'd1, 32'h0000_7777, 1'b0}, // R7
      {4'd4,  3'b100, 32'hFC43_0005, 2'd2, 32'h0000_0000, 1'b0}, // R4 uses prefix
      {4'd7,  3'b100, 32'h3000_0002, 2'd1, 32'h0000_0002, 1'b0}, // R7
      {4'd7,  3'b100, 32'hB000_1234, 2'd1, 32'h0000_1234, 1'b0}, // R7
      {4'd6,  3'b100, 32'hB000_8000, 2'd1, 32'h1234_8000, 1'b0}, // R6 chained
      {4'd6,  3'b100, 32'h3000_0002, 2'd1, 32'h8000_0002, 1'b0}  // R6
   };

   function automatic logic [31:0] to_mem(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag, input logic [31:0] w, input logic ev,
                          input logic [1:0] fmt, input logic [31:0] op, input logic ibe);
      chk({tag, " valid"},   {31'd0, out_valid}, {31'd0, ev});
      chk({tag, " ibe"},     {31'd0, out_ibe}, {31'd0, ibe});
      chk({tag, " fmt"},     {30'd0, out_fmt}, {30'd0, fmt});
      chk({tag, " rsvd"},    {31'd0, out_rsvd}, {31'd0, ev && fmt == 2'd2});
      chk({tag, " operand"}, out_operand, op);
      chk({tag, " opcode"},  {26'd0, out_opcode}, ev ? {26'd0, w[31:26]} : 32'd0);
      chk({tag, " rd"},      {27'd0, out_rd}, ev ? {27'd0, w[25:21]} : 32'd0);
      chk({tag, " ra"},      {27'd0, out_ra}, ev ? {27'd0, w[20:16]} : 32'd0);
      chk({tag, " rb"},      {27'd0, out_rb}, (ev && fmt == 2'd0) ? {27'd0, w[15:11]} : 32'd0);
      chk({tag, " imm11"},   {21'd0, out_imm11}, (ev && fmt == 2'd0) ? {21'd0, w[10:0]} : 32'd0);
   endtask

   task automatic step(input logic v, input logic fe, input logic ex, input logic [31:0] w_mem);
      @(negedge clk);
      in_valid     = v;
      in_fetch_err = fe;
      exc_enter    = ex;
      in_word      = w_mem;
      #2;
   endtask

   initial begin
      #2000000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R10: reset state, a prefix word offered during reset does not arm
      step(1'b0, 1'b0, 1'b0, 32'h0);
      chk_all("R10 reset idle", 32'h0, 1'b0, 2'd0, 32'h0, 1'b0);
      step(1'b1, 1'b0, 1'b0, to_mem(32'hB000_9999));
      step(1'b0, 1'b0, 1'b0, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [73:0] e;
         e = VEC[i];
         step(e[69], e[68], e[67], to_mem(e[66:35]));
         chk_all($sformatf("R%0d vec%0d", e[73:70], i), e[66:35],
                 e[69] && !e[68], e[34:33], e[32:1], e[0]);
      end

      // R1: explicit memory-order word, decoded after byte reversal
      step(1'b1, 1'b0, 1'b0, 32'h3412_6420);
      chk("R1 opcode",  {26'd0, out_opcode}, 32'h08);
      chk("R1 rd",      {27'd0, out_rd}, 32'd3);
      chk("R1 ra",      {27'd0, out_ra}, 32'd4);
      chk("R1 operand", out_operand, 32'h0000_1234);

      // R10: asynchronous reset drops a pending prefix
      step(1'b1, 1'b0, 1'b0, to_mem(32'hB000_ABCD));
      step(1'b0, 1'b0, 1'b0, 32'h0);
      rst_n = 1'b0;
      #1;
      chk_all("R10 in reset", 32'h0, 1'b0, 2'd0, 32'h0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, 1'b0, 1'b0, to_mem(32'h2022_8001));
      chk("R10 pending cleared", out_operand, 32'hFFFF_8001);

      step(1'b0, 1'b0, 1'b0, 32'h0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule